// File: doc/BRIEF.md
# Capture/Compare Event Timer

This block is an up-counter of configurable width (16 bits by default) with one compare register and one capture register. Each count step comes from a count-enable strobe. Software chooses between two sources: an internal tick, which the surrounding logic has already prescaled, or the rising edge of an external event input. A start/stop control gates counting. A synchronous clear returns the counter to zero.

Three counting modes are available. In free-running mode the counter wraps from all-ones to zero. In match-clear mode the counter returns to zero on the step taken from the compare value. In edge-clear mode the counter returns to zero on a rising edge of the capture input. A rising edge of the capture input always stores the current count. A compare hit raises a one-cycle interrupt pulse, and every wrap raises a one-cycle overflow pulse.

Software reads the counter through a read strobe. The read holds back count steps for that cycle and applies them afterwards, so a read never loses a step. A compare hit is counted only when the counter reached the compare value by counting. A start, a clear or a reset does not produce a hit. As a result, a compare value of zero hits only on the step after a wrap. A compare value written below the current count is first reached after the counter has run through overflow.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the counter, the read-back register and the capture register are 0, the compare register holds all-ones, and match_irq and ovf_pulse are low.
- R2: With src_sel=0, each cycle with int_tick high gives one count step. With src_sel=1, only a rising edge of ext_evt gives a step, and int_tick is ignored. An ext_evt held high counts once.
- R3: With run=0 the counter holds its value and no tick is counted. sw_clear sets the counter to 0 on the next edge and drops any deferred ticks.
- R4: mode=2'b00 (or 2'b11) runs free. A step from all-ones wraps the counter to 0, and ovf_pulse is high for exactly the following cycle.
- R5: A count step taken while the counter equals the compare value, with that value reached by a count step, drives match_irq high for exactly the following cycle.
- R6: In mode=2'b01 the step that produces a compare hit loads 0 instead of incrementing, so a compare value C gives one hit every C+1 steps.
- R7: A compare value of 0 hits only on the step from 0 to 1 after a wrap. In mode=2'b01 a compare value of 0 therefore gives no hit in the first pass after a clear.
- R8: If the compare value is rewritten below the current count, the counter runs up through all-ones and 0, and the hit first occurs on the step from the new value.
- R9: In mode=2'b10 a rising edge of cap_in loads the counter with 0 and copies the count held just before the clear into the capture register.
- R10: The capture register loads the count on a rising edge of cap_in in every mode, and only then. A counter read never changes it.
- R11: A cnt_rd pulse puts the count into cnt_rdata in the next cycle. No step is taken in the read cycle. A tick that arrives during the read is deferred and applied later, and up to 2^PEND_W-1 deferred ticks are kept.
- R12: A cmp_wr pulse loads cmp_wdata into the compare register, and cmp_rdata shows it from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 enables counting, 0 holds the counter |
| sw_clear | input | 1 | Synchronous counter clear |
| mode | input | 2 | 00 free-run, 01 match-clear, 10 edge-clear, 11 as 00 |
| src_sel | input | 1 | 0 internal tick, 1 external event edge |
| int_tick | input | 1 | Prescaled internal count strobe |
| ext_evt | input | 1 | External event input (rising edge counts) |
| cap_in | input | 1 | Capture / edge-clear input (rising edge) |
| cnt_rd | input | 1 | Counter read strobe |
| cnt_rdata | output | WIDTH | Count latched by the last read |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | WIDTH | Compare write data |
| cmp_rdata | output | WIDTH | Compare register contents |
| cap_rdata | output | WIDTH | Capture register contents |
| match_irq | output | 1 | One-cycle compare interrupt pulse |
| ovf_pulse | output | 1 | One-cycle overflow pulse |

## Verification
The bench builds the block with WIDTH=8 and PEND_W=2. With the narrow counter a full wrap takes 256 steps, so the wrap, the zero-compare hit after overflow and the run-through on a lowered compare value are all cheap to reach in directed cases. It also lets random stimulus pass through all-ones many times. With a two-bit deferral counter, random back-to-back reads under a steady tick fill the deferral counter and hold it at its limit of 3.

// File: rtl/cctmr_pkg.sv
package cctmr_pkg;

  typedef enum logic [1:0] {
    CM_FREE      = 2'b00,
    CM_MATCH_CLR = 2'b01,
    CM_EDGE_CLR  = 2'b10,
    CM_RSVD      = 2'b11
  } cnt_mode_e;

endpackage

// File: rtl/cctmr_edge_det.sv
module cctmr_edge_det #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] rise
);

  logic [LANES-1:0] prev_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= din[i];
    end
    assign rise[i] = din[i] & ~prev_q[i];
  end

endmodule

// File: rtl/cctmr_tick_gate.sv
module cctmr_tick_gate #(
  parameter int PEND_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic rd_hold,
  input  logic tick,
  output logic step
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

  logic [PEND_W-1:0] pend_q;
  logic              tick_g;
  logic              have_pend;

  assign tick_g    = run & tick;
  assign have_pend = (pend_q != '0);
  assign step      = run & ~rd_hold & (tick_g | have_pend);

  // deferred ticks: grow while the count input is held, drain one per free cycle
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pend_q <= '0;
    end else if (tick_g && !step) begin
      if (pend_q != PEND_MAX) pend_q <= pend_q + PEND_ONE;
    end else if (!tick_g && step) begin
      pend_q <= pend_q - PEND_ONE;
    end
  end

endmodule

// File: rtl/cctmr_core.sv
module cctmr_core
  import cctmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  cnt_mode_e        mode,
  input  logic             step,
  input  logic             cap_edge,
  input  logic [WIDTH-1:0] cmp_val,
  output logic [WIDTH-1:0] cnt_q,
  output logic [WIDTH-1:0] cap_q,
  output logic             irq_q,
  output logic             ovf_q
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] CNT_ONE  = WIDTH'(1);

  logic arrived_q;   // current value was reached by a count step
  logic edge_clr;
  logic hit;
  logic at_top;

  assign edge_clr = (mode == CM_EDGE_CLR) & cap_edge;
  assign hit      = step & arrived_q & (cnt_q == cmp_val);
  assign at_top   = (cnt_q == ALL_ONES);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      cap_q     <= '0;
      arrived_q <= 1'b0;
      irq_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
      if (cap_edge) cap_q <= cnt_q;
      if (clr || edge_clr) begin
        cnt_q     <= '0;
        arrived_q <= 1'b0;
      end else if (step) begin
        irq_q <= hit;
        if (hit && mode == CM_MATCH_CLR) begin
          cnt_q     <= '0;
          arrived_q <= 1'b0;
        end else begin
          cnt_q     <= cnt_q + CNT_ONE;
          arrived_q <= 1'b1;
          ovf_q     <= at_top;
        end
      end
    end
  end

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import cctmr_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int PEND_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sw_clear,
  input  logic [1:0]       mode,
  input  logic             src_sel,
  input  logic             int_tick,
  input  logic             ext_evt,
  input  logic             cap_in,
  input  logic             cnt_rd,
  output logic [WIDTH-1:0] cnt_rdata,
  input  logic             cmp_wr,
  input  logic [WIDTH-1:0] cmp_wdata,
  output logic [WIDTH-1:0] cmp_rdata,
  output logic [WIDTH-1:0] cap_rdata,
  output logic             match_irq,
  output logic             ovf_pulse
);

  localparam int LANE_EXT = 0;
  localparam int LANE_CAP = 1;

  logic [1:0]       rises;
  logic             ext_rise;
  logic             cap_rise;
  logic             tick_sel;
  logic             step;
  logic [WIDTH-1:0] cnt_val;
  logic [WIDTH-1:0] cmp_q;
  cnt_mode_e        mode_e;

  assign mode_e = cnt_mode_e'(mode);

  cctmr_edge_det #(.LANES(2)) u_edges (
    .clk  (clk),
    .rst  (rst),
    .din  ({cap_in, ext_evt}),
    .rise (rises)
  );

  assign ext_rise = rises[LANE_EXT];
  assign cap_rise = rises[LANE_CAP];
  assign tick_sel = src_sel ? ext_rise : int_tick;

  cctmr_tick_gate #(.PEND_W(PEND_W)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .clr     (sw_clear),
    .run     (run),
    .rd_hold (cnt_rd),
    .tick    (tick_sel),
    .step    (step)
  );

  always_ff @(posedge clk) begin
    if (rst)         cmp_q <= '1;
    else if (cmp_wr) cmp_q <= cmp_wdata;
  end

  cctmr_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst      (rst),
    .clr      (sw_clear),
    .mode     (mode_e),
    .step     (step),
    .cap_edge (cap_rise),
    .cmp_val  (cmp_q),
    .cnt_q    (cnt_val),
    .cap_q    (cap_rdata),
    .irq_q    (match_irq),
    .ovf_q    (ovf_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)         cnt_rdata <= '0;
    else if (cnt_rd) cnt_rdata <= cnt_val;
  end

  assign cmp_rdata = cmp_q;

endmodule

// File: rtl/cctmr_checker.sv
module cctmr_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             sw_clear,
  input logic [1:0]       mode,
  input logic             cnt_rd,
  input logic             cap_rise,
  input logic             step,
  input logic [WIDTH-1:0] cnt_val,
  input logic [WIDTH-1:0] cap_rdata,
  input logic             match_irq,
  input logic             ovf_pulse
);

  logic edge_clear;
  assign edge_clear = (mode == 2'b10) & cap_rise;

  p_read_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt_rd && !sw_clear && !edge_clear) |=> (cnt_val == $past(cnt_val)));

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !sw_clear && !edge_clear) |=> (cnt_val == $past(cnt_val)));

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    sw_clear |=> (cnt_val == '0));

  p_ovf_wraps_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> (cnt_val == '0));

  p_irq_after_step_r5: assert property (@(posedge clk) disable iff (rst)
    match_irq |-> $past(step));

  p_match_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (match_irq && $past(mode) == 2'b01) |-> (cnt_val == '0));

  p_cap_edge_only_r10: assert property (@(posedge clk) disable iff (rst)
    !cap_rise |=> (cap_rdata == $past(cap_rdata)));

endmodule

bind capcmp_timer cctmr_checker #(.WIDTH(WIDTH)) u_cctmr_checker (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .sw_clear  (sw_clear),
  .mode      (mode),
  .cnt_rd    (cnt_rd),
  .cap_rise  (cap_rise),
  .step      (step),
  .cnt_val   (cnt_val),
  .cap_rdata (cap_rdata),
  .match_irq (match_irq),
  .ovf_pulse (ovf_pulse)
);

// File: tb/capcmp_timer_bench.sv
`timescale 1ns/1ps
module capcmp_timer_bench;

  localparam int W      = 8;
  localparam int PW     = 2;
  localparam int TOP    = (1 << W) - 1;
  localparam int PMAX   = (1 << PW) - 1;
  localparam int WD_CYC = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run = 1'b0, sw_clear = 1'b0, src_sel = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         int_tick = 1'b0, ext_evt = 1'b0, cap_in = 1'b0;
  logic         cnt_rd = 1'b0, cmp_wr = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic [W-1:0] cnt_rdata, cmp_rdata, cap_rdata;
  logic         match_irq, ovf_pulse;

  int checks = 0, failures = 0;
  int n_irq = 0, n_ovf = 0;
  bit done = 1'b0;
  bit chk_en = 1'b0;

  always #5 clk = ~clk;

  capcmp_timer #(.WIDTH(W), .PEND_W(PW)) u_capcmp_timer (
    .clk(clk), .rst(rst), .run(run), .sw_clear(sw_clear), .mode(mode),
    .src_sel(src_sel), .int_tick(int_tick), .ext_evt(ext_evt), .cap_in(cap_in),
    .cnt_rd(cnt_rd), .cnt_rdata(cnt_rdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .cmp_rdata(cmp_rdata), .cap_rdata(cap_rdata), .match_irq(match_irq),
    .ovf_pulse(ovf_pulse)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model of the requirements, advanced on each rising edge
  int m_cnt, m_cap, m_cmp, m_rd, m_pend;
  bit m_arr, m_irq, m_ovf, m_extp, m_capp;
  bit e_ext, e_cap, tk, tg, stp, hit, eclr;

  always @(posedge clk) begin
    e_ext = ext_evt & ~m_extp;
    e_cap = cap_in & ~m_capp;
    m_extp = ext_evt;
    m_capp = cap_in;
    if (rst) begin
      m_cnt = 0; m_cap = 0; m_cmp = TOP; m_rd = 0; m_pend = 0;
      m_arr = 0; m_irq = 0; m_ovf = 0; m_extp = 0; m_capp = 0;
    end else begin
      tk   = src_sel ? e_ext : int_tick;
      tg   = run & tk;
      stp  = run & ~cnt_rd & (tg | (m_pend != 0));
      eclr = (mode == 2'b10) & e_cap;
      hit  = stp & m_arr & (m_cnt == m_cmp);
      m_irq = 0;
      m_ovf = 0;
      if (cnt_rd) m_rd = m_cnt;
      if (e_cap) m_cap = m_cnt;
      if (sw_clear) m_pend = 0;
      else if (tg && !stp) begin if (m_pend != PMAX) m_pend++; end
      else if (!tg && stp) m_pend--;
      if (sw_clear || eclr) begin
        m_cnt = 0; m_arr = 0;
      end else if (stp) begin
        m_irq = hit;
        if (hit && mode == 2'b01) begin
          m_cnt = 0; m_arr = 0;
        end else begin
          m_ovf = (m_cnt == TOP);
          m_cnt = (m_cnt + 1) & TOP;
          m_arr = 1;
        end
      end
      if (cmp_wr) m_cmp = cmp_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (match_irq) n_irq++;
      if (ovf_pulse) n_ovf++;
      if (chk_en) begin
        check("R5 match_irq", match_irq, m_irq);
        check("R4 ovf_pulse", ovf_pulse, m_ovf);
        check("R10 cap_rdata", cap_rdata, m_cap);
        check("R12 cmp_rdata", cmp_rdata, m_cmp);
        check("R11 cnt_rdata", cnt_rdata, m_rd);
      end
    end
  end

  task automatic ticks(int n);
    int_tick = 1'b1;
    repeat (n) @(negedge clk);
    int_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_cnt(output int v);
    cnt_rd = 1'b1;
    @(negedge clk);
    cnt_rd = 1'b0;
    v = cnt_rdata;
  endtask

  task automatic write_cmp(int v);
    cmp_wr = 1'b1;
    cmp_wdata = W'(v);
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic do_clear();
    sw_clear = 1'b1;
    @(negedge clk);
    sw_clear = 1'b0;
    @(negedge clk);
    n_irq = 0;
    n_ovf = 0;
  endtask

  initial begin
    #(WD_CYC * 10);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 cnt_rdata", cnt_rdata, 0);
    check("R1 cap_rdata", cap_rdata, 0);
    check("R1 cmp_rdata", cmp_rdata, TOP);
    check("R1 match_irq", match_irq, 0);
    check("R1 ovf_pulse", ovf_pulse, 0);
    read_cnt(v); check("R1 counter", v, 0);
    chk_en = 1'b1;
    run = 1'b1;

    // R12 compare write and read-back
    write_cmp(8'h5A);
    check("R12 readback", cmp_rdata, 8'h5A);

    // R3 stop and clear
    do_clear();
    ticks(10);
    run = 1'b0;
    ticks(5);
    read_cnt(v); check("R3 held", v, 10);
    run = 1'b1;
    do_clear();
    read_cnt(v); check("R3 cleared", v, 0);

    // R2 external edge source, int_tick ignored
    src_sel = 1'b1;
    int_tick = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ext_evt = 1'b1; repeat (3) @(negedge clk);
      ext_evt = 1'b0; repeat (2) @(negedge clk);
    end
    int_tick = 1'b0;
    src_sel = 1'b0;
    @(negedge clk);
    read_cnt(v); check("R2 edge count", v, 5);

    // R4 and R7: free-run, compare zero
    mode = 2'b00;
    write_cmp(0);
    do_clear();
    ticks(256);
    check("R7 no hit before wrap", n_irq, 0);
    check("R4 one wrap", n_ovf, 1);
    read_cnt(v); check("R4 wrapped", v, 0);
    ticks(1);
    check("R7 hit after wrap", n_irq, 1);
    read_cnt(v); check("R7 count", v, 1);

    // R7 match-clear with compare zero: no one-step pulse
    mode = 2'b01;
    do_clear();
    ticks(10);
    check("R7 match-clear zero", n_irq, 0);
    read_cnt(v); check("R7 keeps counting", v, 10);

    // R6 match-clear period
    write_cmp(5);
    do_clear();
    ticks(18);
    check("R6 hits", n_irq, 3);
    read_cnt(v); check("R6 cleared", v, 0);

    // R8 compare lowered below count
    mode = 2'b00;
    write_cmp(TOP);
    do_clear();
    ticks(100);
    write_cmp(50);
    n_irq = 0;
    ticks(206);
    check("R8 no early hit", n_irq, 0);
    read_cnt(v); check("R8 ran through wrap", v, 50);
    ticks(1);
    check("R8 late hit", n_irq, 1);

    // R9 edge clear with capture
    mode = 2'b10;
    do_clear();
    ticks(30);
    cap_in = 1'b1; @(negedge clk);
    cap_in = 1'b0; @(negedge clk);
    check("R9 captured", cap_rdata, 30);
    read_cnt(v); check("R9 cleared", v, 0);
    read_cnt(v);
    check("R10 read leaves capture", cap_rdata, 30);

    // R10 capture without clear in free-run
    mode = 2'b00;
    ticks(7);
    cap_in = 1'b1; @(negedge clk);
    cap_in = 1'b0; @(negedge clk);
    check("R10 captured", cap_rdata, 7);
    read_cnt(v); check("R10 no clear", v, 7);

    // R11 reads under a steady tick lose no step
    do_clear();
    int_tick = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cnt_rd = (i == 5 || i == 10 || i == 15);
      @(negedge clk);
    end
    cnt_rd = 1'b0;
    int_tick = 1'b0;
    repeat (3) @(negedge clk);
    read_cnt(v); check("R11 no lost tick", v, 20);

    // random phase checked against the model
    for (int i = 0; i < 6000; i++) begin
      run       = ($urandom_range(0, 9) != 0);
      int_tick  = $urandom_range(0, 1);
      ext_evt   = $urandom_range(0, 1);
      cap_in    = ($urandom_range(0, 29) == 0);
      cnt_rd    = ($urandom_range(0, 9) == 0);
      sw_clear  = ($urandom_range(0, 199) == 0);
      cmp_wr    = ($urandom_range(0, 39) == 0);
      cmp_wdata = W'($urandom_range(0, TOP));
      if ($urandom_range(0, 99) == 0) mode = 2'($urandom_range(0, 2));
      if ($urandom_range(0, 199) == 0) src_sel = ~src_sel;
      @(negedge clk);
    end
    run = 1'b0; int_tick = 1'b0; ext_evt = 1'b0; cap_in = 1'b0;
    cnt_rd = 1'b0; sw_clear = 1'b0; cmp_wr = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule